// File: doc/BRIEF.md
# Write-Through Snooping Cache with Valid/Invalid Lines

This block is a direct-mapped cache for one processor on a shared snooping bus. Each line is either valid or invalid. Coherence comes from two rules working together. Every processor write is sent through to memory on the bus. Any write that another agent puts on the bus clears the local copy of that address. Several caches may therefore hold the same line for reading. Once one of them writes, the copies in all the others are gone.

The processor presents one access at a time and waits for the single-cycle `cpu_done` pulse before it presents the next. A read hit is answered from the cache without using the bus. A read miss, and every write, raises `bus_req` and holds the command, address and write data on the bus until the arbiter grants it. The transfer completes atomically in the grant cycle, and memory returns read data in that same cycle. A write miss leaves the cache unchanged. The snoop inputs carry the transactions that other agents drive on the bus.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset, every line is invalid, and `bus_req` and `cpu_done` are low.
- R2: A read that hits returns the cached word on `cpu_rdata`, with `cpu_done` high in the cycle after the request. `bus_req` is never raised for that access.
- R3: A read that misses raises `bus_req` with `bus_we`=0 and the request address on the following cycle. In the grant cycle the line is filled from `bus_rdata`. The next cycle shows that word with `cpu_done` high, and `bus_req` goes low.
- R4: Every write raises `bus_req` with `bus_we`=1, the write address and the write data, whether it hits or misses. Memory takes the data in the grant cycle, and `cpu_done` pulses the cycle after.
- R5: A write that hits also updates the cached word, so a later read of that address hits and returns the new value.
- R6: A write that misses does not allocate a line, so a later read of that address misses.
- R7: A snooped write (`snoop_valid`=1, `snoop_we`=1) to an address held valid invalidates that line. A snooped write to a different tag on the same index, and any snooped read, leave the line valid.
- R8: A snooped write that arrives in the same cycle as a processor read of the same held address takes priority. The read is handled as a miss and returns the newly written memory value.
- R9: While `bus_req` is high and `bus_gnt` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, taken only when the cache is idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; the low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_done` is high |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request, held until granted |
| bus_gnt | input | 1 | Arbiter grant; the transfer completes in this cycle |
| bus_we | output | 1 | Bus command: 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Memory read data, valid in the grant cycle |
| snoop_valid | input | 1 | Another agent's transaction is on the bus |
| snoop_we | input | 1 | The snooped transaction is a write |
| snoop_addr | input | ADDR_W | Address of the snooped transaction |

## Verification
Two functions can fall in the same cycle: a processor lookup and a snoop invalidation that both target the same line. The bench provokes this by driving a read request and a snooped write to the same held address on one clock edge. It also drives snoops to the same index with a different tag, which must not interfere. A cycle-by-cycle model in the bench applies the snoop before it decides whether the lookup hits. The bench compares `cpu_done`, `cpu_rdata` and the bus outputs against that model on every clock, and it counts bus cycles to show the read was served from memory. Random phases mix accesses, snoops and withheld grants.

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snoop_valid,
  input  logic              snoop_we,
  input  logic [ADDR_W-1:0] snoop_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tags [LINES];
  logic [DATA_W-1:0] data [LINES];

  logic              busy, pend_we;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snoop_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snoop_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] p_idx = pend_addr[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = pend_addr[ADDR_W-1:IDX_W];

  wire snoop_kill = snoop_valid && snoop_we && vld[s_idx] && (tags[s_idx] == s_tag);
  wire c_hit      = vld[c_idx] && (tags[c_idx] == c_tag) && !(snoop_kill && (s_idx == c_idx));
  wire accept     = !busy && cpu_req;
  wire rd_hit     = accept && !cpu_we && c_hit;
  wire to_bus     = accept && !rd_hit;
  wire xfer       = busy && bus_gnt;

  assign bus_req   = busy;
  assign bus_we    = pend_we;
  assign bus_addr  = pend_addr;
  assign bus_wdata = pend_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      busy      <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      if (rd_hit) begin
        cpu_done  <= 1'b1;
        cpu_rdata <= data[c_idx];
      end else if (to_bus) begin
        busy <= 1'b1;
      end else if (xfer) begin
        busy     <= 1'b0;
        cpu_done <= 1'b1;
        if (!pend_we) begin
          cpu_rdata  <= bus_rdata;
          vld[p_idx] <= 1'b1;
        end
      end
      if (snoop_kill) vld[s_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (to_bus) begin
      pend_we    <= cpu_we;
      pend_addr  <= cpu_addr;
      pend_wdata <= cpu_wdata;
    end
    if (to_bus && cpu_we && c_hit) data[c_idx] <= cpu_wdata;
    if (xfer && !pend_we) begin
      tags[p_idx] <= p_tag;
      data[p_idx] <= bus_rdata;
    end
  end

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> cpu_done && !bus_req); // R2
  AST_GNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> cpu_done && !bus_req); // R3
  AST_WRITE_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_we) |=> bus_req && bus_we && (bus_addr == $past(cpu_addr))); // R4
  AST_NO_WRITE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_we && !c_hit) |=> !(vld[$past(c_idx)] && (tags[$past(c_idx)] == $past(c_tag)))); // R6
  AST_SNOOP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_kill |=> !vld[$past(s_idx)]); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R9
endmodule

// File: tb/test_wt_snoop_cache.sv
module test_wt_snoop_cache;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int IW = 3;
  localparam int NL = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [DW-1:0] cpu_wdata = 0;
  logic [DW-1:0] cpu_rdata;
  logic cpu_done, bus_req, bus_we, bus_gnt;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic snoop_valid = 0, snoop_we = 0;
  logic [AW-1:0] snoop_addr = 0;
  logic [DW-1:0] snoop_data = 0;
  logic gnt_en = 1, rand_gnt = 0;

  logic [DW-1:0] mem [1<<AW];
  int checks = 0, fails = 0, cyc = 0, bus_cycles = 0;

  assign bus_gnt   = bus_req & gnt_en;
  assign bus_rdata = mem[bus_addr];

  always #(CLK_P/2) clk = ~clk;

  wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) i_wt_snoop_cache (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_done,
    .bus_req, .bus_gnt, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .snoop_valid, .snoop_we, .snoop_addr);

  always @(posedge clk) begin
    if (bus_req && bus_gnt && bus_we) mem[bus_addr] <= bus_wdata;
    if (snoop_valid && snoop_we) mem[snoop_addr] <= snoop_data;
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Reference model of the requirements
  bit m_v [NL];
  int m_t [NL];
  logic [DW-1:0] m_d [NL];
  bit m_busy = 0, m_we = 0, m_done = 0;
  logic [AW-1:0] m_addr = 0;
  logic [DW-1:0] m_wd = 0, m_rd = 0;

  always @(posedge clk) begin
    cyc++;
    if (bus_req) bus_cycles++;
    if (!rst_n) begin
      foreach (m_v[k]) m_v[k] = 0;
      m_busy = 0; m_done = 0; m_rd = 0;
    end else begin
      int si, ci;
      bit kill, hit;
      si = snoop_addr % NL;
      ci = cpu_addr % NL;
      kill = snoop_valid && snoop_we && m_v[si] && m_t[si] == snoop_addr / NL;
      hit = m_v[ci] && m_t[ci] == cpu_addr / NL && !(kill && si == ci);
      m_done = 0;
      if (!m_busy && cpu_req) begin
        if (!cpu_we && hit) begin
          m_done = 1; m_rd = m_d[ci];
        end else begin
          m_busy = 1; m_we = cpu_we; m_addr = cpu_addr; m_wd = cpu_wdata;
          if (cpu_we && hit) m_d[ci] = cpu_wdata;
        end
      end else if (m_busy && gnt_en) begin
        m_busy = 0; m_done = 1;
        if (!m_we) begin
          m_rd = mem[m_addr];
          m_v[m_addr % NL] = 1; m_t[m_addr % NL] = m_addr / NL; m_d[m_addr % NL] = mem[m_addr];
        end
      end
      if (kill) m_v[si] = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cpu_done == m_done, "R2 done", DW'(cpu_done), DW'(m_done));
      if (m_done) chk(cpu_rdata == m_rd, "R3 rdata", cpu_rdata, m_rd);
      chk(bus_req == m_busy, "R9 bus_req", DW'(bus_req), DW'(m_busy));
      if (m_busy) begin
        chk(bus_addr == m_addr && bus_we == m_we, "R9 cmd/addr", DW'({bus_we, bus_addr}), DW'({m_we, m_addr}));
        if (m_we) chk(bus_wdata == m_wd, "R4 wdata", bus_wdata, m_wd);
      end
    end
    if (rand_gnt) gnt_en <= ($urandom % 3) != 0;
  end

  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  logic [DW-1:0] last_rd;
  int used;

  task automatic op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit with_snoop = 0,
                    input logic [DW-1:0] sd = 0);
    int b0;
    @(negedge clk);
    b0 = bus_cycles;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (with_snoop) begin snoop_valid = 1; snoop_we = 1; snoop_addr = a; snoop_data = sd; end
    @(negedge clk);
    cpu_req = 0; snoop_valid = 0;
    while (!cpu_done) @(negedge clk);
    last_rd = cpu_rdata;
    used = bus_cycles - b0;
  endtask

  task automatic snoop(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    snoop_valid = 1; snoop_we = we; snoop_addr = a; snoop_data = d;
    @(negedge clk);
    snoop_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 32'hA500_0000 + i * 32'h0101;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_req == 0 && cpu_done == 0, "R1 idle after reset", DW'({bus_req, cpu_done}), 0);
    op(0, 8'h11, 0);
    chk(used > 0, "R1 first read misses", DW'(used), 1);
    chk(last_rd == mem[8'h11], "R3 miss data", last_rd, mem[8'h11]);
    op(0, 8'h11, 0);
    chk(used == 0, "R2 hit uses no bus", DW'(used), 0);
    chk(last_rd == mem[8'h11], "R2 hit data", last_rd, mem[8'h11]);
    op(1, 8'h11, 32'hC0DE_0001);
    chk(used > 0, "R4 write hit on bus", DW'(used), 1);
    chk(mem[8'h11] == 32'hC0DE_0001, "R4 memory updated", mem[8'h11], 32'hC0DE_0001);
    op(0, 8'h11, 0);
    chk(used == 0 && last_rd == 32'hC0DE_0001, "R5 write hit updates copy", last_rd, 32'hC0DE_0001);
    op(1, 8'h22, 32'hC0DE_0002);
    op(0, 8'h22, 0);
    chk(used > 0, "R6 write miss no allocate", DW'(used), 1);
    chk(last_rd == 32'hC0DE_0002, "R6 data via memory", last_rd, 32'hC0DE_0002);
    snoop(1, 8'h19, 32'h5555_0019);
    op(0, 8'h11, 0);
    chk(used == 0, "R7 other tag snoop keeps line", DW'(used), 0);
    snoop(0, 8'h11, 0);
    op(0, 8'h11, 0);
    chk(used == 0, "R7 snooped read keeps line", DW'(used), 0);
    snoop(1, 8'h11, 32'h5555_0011);
    op(0, 8'h11, 0);
    chk(used > 0 && last_rd == 32'h5555_0011, "R7 snooped write invalidates", last_rd, 32'h5555_0011);
    op(0, 8'h11, 0, 1, 32'h7777_0011);
    chk(used > 0, "R8 same-cycle snoop forces miss", DW'(used), 1);
    chk(last_rd == 32'h7777_0011, "R8 new value", last_rd, 32'h7777_0011);
    fork
      op(1, 8'h33, 32'hBEEF_0033);
      begin @(negedge clk); gnt_en = 0; repeat (6) @(negedge clk); gnt_en = 1; end
    join
    chk(used >= 6, "R9 request held until grant", DW'(used), 6);
    chk(mem[8'h33] == 32'hBEEF_0033, "R9 write lands", mem[8'h33], 32'hBEEF_0033);
    rand_gnt = 1;
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a;
      a = AW'({$urandom % 4, 3'($urandom % NL)});
      case ($urandom % 5)
        0: op(1, a, $urandom);
        1: snoop($urandom % 2, a, $urandom);
        2: op(0, a, 0, 1, $urandom);
        default: op(0, a, 0);
      endcase
    end
    rand_gnt = 0; gnt_en = 1;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule